// File: doc/BRIEF.md
# Thermostat Alert with Consecutive-Fault Filter

This block decides when a temperature monitor raises its alert output. Each time a new 12-bit signed temperature result is announced by a one-cycle strobe, the block compares it against a high limit and a low limit. A programmable filter demands a run of consecutive faulting results before the alert changes state, so isolated noisy readings never reach the pin. The block is placed between a converter (which produces the results) and a register interface (which supplies the limits and configuration and reports reads). Conversion and the serial bus are outside it.

Two thermostat behaviours are offered. In comparator behaviour the alert is a hysteresis level: it turns on after a run of results at or above the high limit and off after a run below the low limit. In interrupt behaviour the alert is a latched event that software acknowledges. The block alternates between watching the high limit and watching the low limit, and a cause bit reports which limit produced the last assertion. The output polarity is selectable, and a bus-wide reset command returns the internal state to its power-up values.

Top module: `therm_alert`

## Requirements
- R1: The 2-bit filter code `cfg_queue` selects the run length: 0 needs 1, 1 needs 2, 2 needs 4 and 3 needs 6 consecutive faulting results before the alert changes state.
- R2: Any evaluated result that does not meet the fault condition currently being watched sets the run count back to zero.
- R3: With `cfg_intmode`=0 (comparator), the alert turns on after a run of results with temperature >= high limit and turns off only after a run of results with temperature < low limit; results between the limits leave it unchanged.
- R4: In comparator behaviour, `reg_read` and `ar_success` have no effect on the alert.
- R5: With `cfg_intmode`=1 (interrupt), an asserted alert stays asserted regardless of further results until `reg_read`, `ar_success` or `cfg_shutdown` is seen, which clears it the next cycle.
- R6: In interrupt behaviour the watched condition alternates: the first assertion needs a run at or above the high limit (`alert_cause`=1), the next a run below the low limit (`alert_cause`=0), then the high limit again. `alert_cause` holds its value while the alert is asserted.
- R7: `alert_pin` equals the alert state when `cfg_pol`=1 (active high) and its inverse when `cfg_pol`=0 (active low).
- R8: Temperature and limits are compared as 12-bit two's-complement values using every bit, so 0x800 is the coldest value and a limit differing only in bit 0 changes the outcome.
- R9: A `gc_reset` pulse clears the alert, the cause bit, the run count and the watched condition (back to the high limit) on the next cycle.
- R10: A change of `cfg_intmode` or `cfg_queue` clears the run count.
- R11: Results are evaluated only in cycles with `sample_valid`=1. If a clear request and a result that completes an interrupt-mode run arrive in the same cycle, the alert ends up asserted.
- R12: After `rst_n` is released the alert is inactive and `alert_cause` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sample_valid | input | 1 | One-cycle strobe: a new temperature result is present |
| sample_temp | input | 12 | Signed temperature result |
| limit_hi | input | 12 | Signed high limit |
| limit_lo | input | 12 | Signed low limit |
| cfg_queue | input | 2 | Run-length code (1/2/4/6) |
| cfg_pol | input | 1 | Output polarity, 1 = active high |
| cfg_intmode | input | 1 | 0 = comparator, 1 = interrupt behaviour |
| cfg_shutdown | input | 1 | Shutdown request; clears an interrupt-mode alert |
| reg_read | input | 1 | Strobe: a register read took place |
| ar_success | input | 1 | Strobe: this device answered an alert-response request |
| gc_reset | input | 1 | Strobe: bus-wide reset command |
| alert_pin | output | 1 | Alert output level after polarity |
| alert_cause | output | 1 | 1 = last assertion from high limit, 0 = from low limit |

## Verification
The two functions that can meet in one cycle are an interrupt-mode acknowledge (a register read) and the result that completes a low-limit run. The bench arms the run one result short, then drives the completing result together with `reg_read` in the same cycle and requires the alert to end asserted with cause 0. A second overlap, a configuration change landing inside a partial run, is provoked by switching the filter code or the mode for a cycle between two faulting results and judged by the alert staying off until a full fresh run has been seen.

// File: rtl/therm_alert_pkg.sv
package therm_alert_pkg;

    // Width of the run counter: it must hold the longest run (6).
    localparam int RUN_W = 3;

    typedef struct packed {
        logic       alert;      // alert state before polarity
        logic       cause;      // 1: high limit, 0: low limit
        logic       watch_low;  // interrupt mode: watching the low limit
        logic       mode_seen;  // last observed cfg_intmode
        logic [1:0] code_seen;  // last observed cfg_queue
    } alert_state_t;

    function automatic logic [RUN_W-1:0] run_length(input logic [1:0] code);
        logic [RUN_W-1:0] len;
        case (code)
            2'd0:    len = RUN_W'(1);
            2'd1:    len = RUN_W'(2);
            2'd2:    len = RUN_W'(4);
            default: len = RUN_W'(6);
        endcase
        return len;
    endfunction

endpackage

// File: rtl/thal_compare.sv
module thal_compare #(
    parameter int TW = 12
) (
    input  logic [TW-1:0] temp,
    input  logic [TW-1:0] hi,
    input  logic [TW-1:0] lo,
    output logic          at_or_above_hi,
    output logic          below_lo
);
    // Full-width signed comparisons (R8).
    always_comb begin
        at_or_above_hi = $signed(temp) >= $signed(hi);
        below_lo       = $signed(temp) <  $signed(lo);
    end
endmodule

// File: rtl/thal_fault_queue.sv
module thal_fault_queue #(
    parameter int RUN_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             step,
    input  logic             fault,
    input  logic [RUN_W-1:0] need,
    output logic             hit,
    output logic [RUN_W-1:0] count
);
    logic [RUN_W-1:0] cnt_d, cnt_q;
    logic [RUN_W-1:0] cnt_next;

    always_comb begin
        cnt_next = cnt_q + RUN_W'(1);
        cnt_d    = cnt_q;
        hit      = 1'b0;
        if (clear) begin
            cnt_d = '0;
        end else if (step) begin
            if (!fault) begin
                cnt_d = '0;
            end else if (cnt_next >= need) begin
                hit   = 1'b1;
                cnt_d = '0;
            end else begin
                cnt_d = cnt_next;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count = cnt_q;

    // R2: a passing result empties the run
    a_r2_pass_resets: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !fault && !clear) |=> (cnt_q == '0));

    // R10: a clear request empties the run
    a_r10_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (cnt_q == '0));

    // R1: a hit starts a fresh run
    a_r1_hit_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> (cnt_q == '0));
endmodule

// File: rtl/therm_alert.sv
module therm_alert
    import therm_alert_pkg::*;
#(
    parameter int TW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sample_valid,
    input  logic [TW-1:0] sample_temp,
    input  logic [TW-1:0] limit_hi,
    input  logic [TW-1:0] limit_lo,
    input  logic [1:0]    cfg_queue,
    input  logic          cfg_pol,
    input  logic          cfg_intmode,
    input  logic          cfg_shutdown,
    input  logic          reg_read,
    input  logic          ar_success,
    input  logic          gc_reset,
    output logic          alert_pin,
    output logic          alert_cause
);
    alert_state_t s_d, s_q;

    logic             ge_hi, lt_lo;
    logic             watching_low;
    logic             fault;
    logic             step;
    logic             cfg_change;
    logic             fq_clear;
    logic             hit;
    logic [RUN_W-1:0] need;
    logic [RUN_W-1:0] run_count;
    logic             ack_req;

    thal_compare #(.TW(TW)) u_cmp (
        .temp           (sample_temp),
        .hi             (limit_hi),
        .lo             (limit_lo),
        .at_or_above_hi (ge_hi),
        .below_lo       (lt_lo)
    );

    always_comb begin
        need         = run_length(cfg_queue);
        cfg_change   = (cfg_intmode != s_q.mode_seen) || (cfg_queue != s_q.code_seen);
        watching_low = cfg_intmode ? s_q.watch_low : s_q.alert;
        fault        = watching_low ? lt_lo : ge_hi;
        // An asserted interrupt-mode alert waits for acknowledge; no counting.
        step         = sample_valid && !(cfg_intmode && s_q.alert);
        fq_clear     = cfg_change || gc_reset;
        ack_req      = reg_read || ar_success || cfg_shutdown;
    end

    thal_fault_queue #(.RUN_W(RUN_W)) u_fq (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (fq_clear),
        .step  (step),
        .fault (fault),
        .need  (need),
        .hit   (hit),
        .count (run_count)
    );

    always_comb begin
        s_d           = s_q;
        s_d.mode_seen = cfg_intmode;
        s_d.code_seen = cfg_queue;
        if (gc_reset) begin
            s_d.alert     = 1'b0;
            s_d.cause     = 1'b0;
            s_d.watch_low = 1'b0;
        end else begin
            // Acknowledge applies only to an alert already present.
            if (cfg_intmode && s_q.alert && ack_req) begin
                s_d.alert = 1'b0;
            end
            if (hit) begin
                if (cfg_intmode) begin
                    s_d.alert     = 1'b1;
                    s_d.cause     = !watching_low;
                    s_d.watch_low = !watching_low;
                end else begin
                    s_d.alert = !s_q.alert;
                    if (!s_q.alert) begin
                        s_d.cause = 1'b1;
                    end
                end
            end
            // Comparator behaviour keeps the watched side aligned with the level
            // so a switch to interrupt behaviour continues consistently.
            if (!cfg_intmode) begin
                s_d.watch_low = s_d.alert;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign alert_pin   = cfg_pol ? s_q.alert : !s_q.alert;
    assign alert_cause = s_q.cause;

    // R11: the alert only rises in response to an evaluated result
    a_r11_rise_needs_sample: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.alert) |-> $past(sample_valid));

    // R4: in comparator behaviour only a result (or bus reset) can drop the alert
    a_r4_cmp_fall_needs_sample: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(s_q.alert) && !$past(cfg_intmode) && !$past(gc_reset)) |-> $past(sample_valid));

    // R5: a register read acknowledges an interrupt-mode alert
    a_r5_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_intmode && s_q.alert && reg_read && !gc_reset) |=> !s_q.alert);

    // R6: the cause bit is frozen while the alert stays asserted
    a_r6_cause_held: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.alert && $past(s_q.alert)) |-> $stable(s_q.cause));

    // R9: bus reset clears alert, cause and run count
    a_r9_gc_clears: assert property (@(posedge clk) disable iff (!rst_n)
        gc_reset |=> (!s_q.alert && !s_q.cause && run_count == '0));
endmodule

// File: tb/therm_alert_test.sv
`timescale 1ns/1ps
module therm_alert_test;
    localparam logic [11:0] LIM_HI = 12'h500; // 80 C
    localparam logic [11:0] LIM_LO = 12'h4B0; // 75 C
    localparam logic [11:0] T_HOT  = 12'h500; // equal to high limit: faults
    localparam logic [11:0] T_MID  = 12'h4C0; // between limits
    localparam logic [11:0] T_COLD = 12'h4AF; // one step below low limit

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sample_valid = 1'b0;
    logic [11:0] sample_temp = '0;
    logic [11:0] limit_hi = LIM_HI;
    logic [11:0] limit_lo = LIM_LO;
    logic [1:0]  cfg_queue = 2'd0;
    logic        cfg_pol = 1'b0;
    logic        cfg_intmode = 1'b0;
    logic        cfg_shutdown = 1'b0;
    logic        reg_read = 1'b0;
    logic        ar_success = 1'b0;
    logic        gc_reset = 1'b0;
    logic        alert_pin;
    logic        alert_cause;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    therm_alert uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .sample_valid (sample_valid),
        .sample_temp  (sample_temp),
        .limit_hi     (limit_hi),
        .limit_lo     (limit_lo),
        .cfg_queue    (cfg_queue),
        .cfg_pol      (cfg_pol),
        .cfg_intmode  (cfg_intmode),
        .cfg_shutdown (cfg_shutdown),
        .reg_read     (reg_read),
        .ar_success   (ar_success),
        .gc_reset     (gc_reset),
        .alert_pin    (alert_pin),
        .alert_cause  (alert_cause)
    );

    function automatic int need_of(input int code);
        return (code == 0) ? 1 : (code == 1) ? 2 : (code == 2) ? 4 : 6;
    endfunction

    task automatic chk(input string req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    // Compare the pin against the expected alert state under current polarity.
    task automatic chk_pin(input string req, input logic active);
        chk(req, alert_pin, cfg_pol ? active : !active);
    endtask

    task automatic samp(input logic [11:0] t);
        @(negedge clk);
        sample_temp  = t;
        sample_valid = 1'b1;
        @(negedge clk);
        sample_valid = 1'b0;
    endtask

    task automatic samp_n(input logic [11:0] t, input int n);
        for (int i = 0; i < n; i++) samp(t);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic pulse_read();
        @(negedge clk); reg_read = 1'b1;
        @(negedge clk); reg_read = 1'b0;
    endtask

    task automatic pulse_ar();
        @(negedge clk); ar_success = 1'b1;
        @(negedge clk); ar_success = 1'b0;
    endtask

    task automatic pulse_sd();
        @(negedge clk); cfg_shutdown = 1'b1;
        @(negedge clk); cfg_shutdown = 1'b0;
    endtask

    task automatic pulse_gc();
        @(negedge clk); gc_reset = 1'b1;
        @(negedge clk); gc_reset = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R12: reset state, both polarities
        do_reset();
        chk("R12 pin after reset (active low)", alert_pin, 1'b1);
        chk("R12 cause after reset", alert_cause, 1'b0);
        cfg_pol = 1'b1;
        @(negedge clk);
        chk("R12/R7 pin after reset (active high)", alert_pin, 1'b0);

        // Comparator sweep over polarity and run-length code
        for (int p = 0; p < 2; p++) begin
            for (int q = 0; q < 4; q++) begin
                int n;
                n = need_of(q);
                cfg_pol     = p[0];
                cfg_queue   = q[1:0];
                cfg_intmode = 1'b0;
                do_reset();
                samp_n(T_HOT, n - 1);
                chk_pin("R1/R7 comparator short high run", 1'b0);
                if (n > 1) begin
                    samp(T_MID);
                    samp_n(T_HOT, n - 1);
                    chk_pin("R2 broken high run restarts", 1'b0);
                end
                samp(T_HOT);
                chk_pin("R1/R3/R7 comparator full high run", 1'b1);
                chk("R3 cause after high assertion", alert_cause, 1'b1);
                pulse_read();
                pulse_ar();
                chk_pin("R4 read and alert response ignored", 1'b1);
                samp_n(T_COLD, n - 1);
                chk_pin("R3 short low run keeps alert", 1'b1);
                samp(T_MID);
                chk_pin("R3 between limits keeps alert", 1'b1);
                if (n > 1) begin
                    samp_n(T_COLD, n - 1);
                    chk_pin("R2 broken low run restarts", 1'b1);
                end
                samp(T_COLD);
                chk_pin("R1/R3 full low run releases", 1'b0);
            end
        end

        // Interrupt sweep over run-length code
        cfg_pol = 1'b1;
        for (int q = 0; q < 4; q++) begin
            int n;
            n = need_of(q);
            cfg_queue   = q[1:0];
            cfg_intmode = 1'b1;
            do_reset();
            samp_n(T_HOT, n - 1);
            chk_pin("R1 interrupt short high run", 1'b0);
            samp(T_HOT);
            chk_pin("R5 interrupt asserts on high run", 1'b1);
            chk("R6 cause high", alert_cause, 1'b1);
            samp_n(T_COLD, 2);
            samp_n(T_MID, 2);
            chk_pin("R5 results do not clear interrupt alert", 1'b1);
            chk("R6 cause held", alert_cause, 1'b1);
            pulse_read();
            chk_pin("R5 read clears", 1'b0);
            samp_n(T_HOT, n + 1);
            chk_pin("R6 high no longer watched", 1'b0);
            samp_n(T_COLD, n);
            chk_pin("R6 low run asserts", 1'b1);
            chk("R6 cause low", alert_cause, 1'b0);
            pulse_ar();
            chk_pin("R5 alert response clears", 1'b0);
            samp_n(T_COLD, n + 1);
            chk_pin("R6 low no longer watched", 1'b0);
            samp_n(T_HOT, n);
            chk_pin("R6 high watched again", 1'b1);
            chk("R6 cause high again", alert_cause, 1'b1);
            pulse_sd();
            chk_pin("R5 shutdown clears", 1'b0);
        end

        // R11: collision of acknowledge and a completing low-run result
        cfg_queue   = 2'd1;
        cfg_intmode = 1'b1;
        do_reset();
        samp_n(T_HOT, 2);
        pulse_read();
        samp(T_COLD);
        @(negedge clk);
        sample_temp  = T_COLD;
        sample_valid = 1'b1;
        reg_read     = 1'b1;
        @(negedge clk);
        sample_valid = 1'b0;
        reg_read     = 1'b0;
        chk_pin("R11 completing result beats same-cycle read", 1'b1);
        chk("R11 cause low after collision", alert_cause, 1'b0);

        // R11: no evaluation without the strobe
        cfg_intmode = 1'b0;
        cfg_queue   = 2'd0;
        do_reset();
        @(negedge clk);
        sample_temp = T_HOT;
        repeat (10) @(negedge clk);
        chk_pin("R11 no strobe no evaluation", 1'b0);

        // R10: code change clears a partial run
        cfg_queue = 2'd1;
        do_reset();
        samp(T_HOT);
        @(negedge clk); cfg_queue = 2'd2;
        @(negedge clk); cfg_queue = 2'd1;
        samp(T_HOT);
        chk_pin("R10 code change cleared run", 1'b0);
        samp(T_HOT);
        chk_pin("R10 fresh run completes", 1'b1);

        // R10: mode change clears a partial run
        do_reset();
        samp(T_HOT);
        @(negedge clk); cfg_intmode = 1'b1;
        @(negedge clk); cfg_intmode = 1'b0;
        samp(T_HOT);
        chk_pin("R10 mode change cleared run", 1'b0);

        // R8: signed full-width comparison
        cfg_queue = 2'd0;
        limit_hi  = 12'h001;
        limit_lo  = 12'hFFF;
        do_reset();
        samp(12'h000);
        chk_pin("R8 bit 0 of high limit matters", 1'b0);
        samp(12'h001);
        chk_pin("R8 equal to high limit asserts", 1'b1);
        samp(12'h000);
        chk_pin("R8 zero not below minus one", 1'b1);
        samp(12'h800);
        chk_pin("R8 0x800 is coldest", 1'b0);
        limit_hi = 12'h7FF;
        samp(12'h800);
        chk_pin("R8 0x800 below top limit", 1'b0);
        limit_hi = LIM_HI;
        limit_lo = LIM_LO;

        // R9: bus reset clears alert, cause and watched side
        cfg_intmode = 1'b1;
        cfg_queue   = 2'd1;
        do_reset();
        samp_n(T_HOT, 2);
        chk_pin("R9 setup asserted", 1'b1);
        pulse_gc();
        chk_pin("R9 bus reset clears alert", 1'b0);
        chk("R9 bus reset clears cause", alert_cause, 1'b0);
        samp_n(T_HOT, 2);
        chk_pin("R9 watching high after bus reset", 1'b1);
        chk("R9 cause high after bus reset", alert_cause, 1'b1);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule